// File: doc/BRIEF.md
# Raster Sync and Blanking Generator

This block produces the horizontal and vertical timing for a progressive raster display. By default the timing is 640x480 at 60 Hz. Two free-running position counters run off the pixel clock. The column counter steps on every rising edge. The row counter steps once each time the column counter wraps. Every timing event (sync start, sync end, visible start, visible end) is found by comparing a counter for equality with a constant.

A comparator that watches a counter which has just stepped can pulse briefly while the counter bits settle. To keep these pulses away from the outputs, every comparator result is captured by a flip-flop on the falling edge of the pixel clock, half a period after the counters move. These clean event strobes then drive set/clear flags on the next rising edge. As a result, the sync, blanking and position outputs all change only on rising edges, and each one stays lined up with the column and row values it describes.

The four segments of a line (visible, front porch, sync, back porch) are parameters, and so are the four segments of a frame. A synchronous reset restarts the raster at the top-left pixel.

Top module: `vid_timing_gen`

## Requirements
- R1: `col` advances by one on every rising clock edge and wraps from H_TOTAL-1 to 0. H_TOTAL = H_ACTIVE+H_FP+H_SYNC+H_BP, which is 800 by default.
- R2: `row` advances by one on exactly the edges where `col` wraps, holds its value on all other edges, and wraps from V_TOTAL-1 to 0. V_TOTAL is 525 by default.
- R3: Timing events come from equality compares that are registered on the falling edge. No output changes at a falling edge.
- R4: `hsync_n` is low exactly while `col` lies in [H_ACTIVE+H_FP, H_ACTIVE+H_FP+H_SYNC), which is 656..751 by default, and high otherwise.
- R5: `vsync_n` is low exactly while `row` lies in [V_ACTIVE+V_FP, V_ACTIVE+V_FP+V_SYNC), which is 490..491 by default, and high otherwise. It changes only on edges where `col` becomes 0.
- R6: `active` is high exactly when `col` < H_ACTIVE and `row` < V_ACTIVE.
- R7: A rising edge with `rst` high sets `col` = 0, `row` = 0, `hsync_n` = 1, `vsync_n` = 1 and `active` = 1. Counting resumes from there, including when reset occurs mid-frame.
- R8: All segment lengths and both counter widths (W_COL, W_ROW, at least 10 bits by default) are parameters. The outputs follow R1–R6 for any legal set of values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; counters step on its rising edge, compares are sampled on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | High during the visible region |
| col | output | W_COL | Current column within the line |
| row | output | W_ROW | Current line within the frame |

## Verification
If a compare constant is wrong, or a falling-edge capture is lost, the effect shows at the ports as a sync or blanking edge at the wrong column. For the horizontal flags this appears within one line. The vertical flags hold their state across a whole frame, so a missed vertical event can stay hidden until the row counter reaches that event, and then it corrupts every line after it. For this reason every output is compared with a range-based model on every clock for several complete frames, and a reset is applied mid-line.

// File: rtl/vt_pkg.sv
package vt_pkg;

  // Indices of the four events decoded per axis.
  localparam int EV_SYNC_ON  = 0;
  localparam int EV_SYNC_OFF = 1;
  localparam int EV_VIS_ON   = 2;
  localparam int EV_VIS_OFF  = 3;
  localparam int EV_COUNT    = 4;

  function automatic int seg_total(input int vis, input int fp, input int sy, input int bp);
    return vis + fp + sy + bp;
  endfunction

  function automatic int sync_first(input int vis, input int fp);
    return vis + fp;
  endfunction

  function automatic int sync_past(input int vis, input int fp, input int sy);
    return vis + fp + sy;
  endfunction

  // Counter value one step before the event takes effect at the output.
  function automatic int ev_const(input int idx, input int vis, input int fp,
                                  input int sy, input int bp);
    case (idx)
      EV_SYNC_ON:  return sync_first(vis, fp) - 1;
      EV_SYNC_OFF: return sync_past(vis, fp, sy) - 1;
      EV_VIS_ON:   return seg_total(vis, fp, sy, bp) - 1;
      default:     return vis - 1;
    endcase
  endfunction

endpackage

// File: rtl/vt_wrap_counter.sv
module vt_wrap_counter #(
  parameter int W    = 10,
  parameter int LAST = 799
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  assign at_last = (cnt == W'(LAST));

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (adv)
      cnt <= at_last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/vt_event_tap.sv
module vt_event_tap #(
  parameter int W = 10,
  parameter int K = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] value,
  output logic         hit
);
  // Sampled half a period after the counter moved, once its bits have settled.
  always_ff @(negedge clk) begin
    if (rst)
      hit <= 1'b0;
    else
      hit <= en && (value == W'(K));
  end
endmodule

// File: rtl/vt_sr_flag.sv
module vt_sr_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q,
  output logic q_nxt
);
  always_comb begin
    if (clr)      q_nxt = 1'b0;
    else if (set) q_nxt = 1'b1;
    else          q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vt_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int W_COL    = 10,
  parameter int W_ROW    = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             active,
  output logic [W_COL-1:0] col,
  output logic [W_ROW-1:0] row
);
  localparam int H_TOTAL = seg_total(H_ACTIVE, H_FP, H_SYNC, H_BP);
  localparam int V_TOTAL = seg_total(V_ACTIVE, V_FP, V_SYNC, V_BP);

  logic line_end;
  logic frame_end;
  logic [EV_COUNT-1:0] h_hit;
  logic [EV_COUNT-1:0] v_hit;

  // Position counters
  vt_wrap_counter #(.W(W_COL), .LAST(H_TOTAL-1)) u_col_cnt (
    .clk(clk), .rst(rst), .adv(1'b1), .cnt(col), .at_last(line_end)
  );

  vt_wrap_counter #(.W(W_ROW), .LAST(V_TOTAL-1)) u_row_cnt (
    .clk(clk), .rst(rst), .adv(line_end), .cnt(row), .at_last(frame_end)
  );

  // Equality decoders, each captured on the falling edge
  for (genvar i = 0; i < EV_COUNT; i++) begin : g_htap
    vt_event_tap #(.W(W_COL), .K(ev_const(i, H_ACTIVE, H_FP, H_SYNC, H_BP))) u_tap (
      .clk(clk), .rst(rst), .en(1'b1), .value(col), .hit(h_hit[i])
    );
  end

  for (genvar i = 0; i < EV_COUNT; i++) begin : g_vtap
    vt_event_tap #(.W(W_ROW), .K(ev_const(i, V_ACTIVE, V_FP, V_SYNC, V_BP))) u_tap (
      .clk(clk), .rst(rst), .en(line_end), .value(row), .hit(v_hit[i])
    );
  end

  // Named event strobes (clean, half-cycle registered)
  logic hs_set_hit, hs_clr_hit, hv_set_hit, hv_clr_hit;
  logic vs_set_hit, vs_clr_hit, vv_set_hit, vv_clr_hit;
  assign hs_set_hit = h_hit[EV_SYNC_ON];
  assign hs_clr_hit = h_hit[EV_SYNC_OFF];
  assign hv_set_hit = h_hit[EV_VIS_ON];
  assign hv_clr_hit = h_hit[EV_VIS_OFF];
  assign vs_set_hit = v_hit[EV_SYNC_ON];
  assign vs_clr_hit = v_hit[EV_SYNC_OFF];
  assign vv_set_hit = v_hit[EV_VIS_ON];
  assign vv_clr_hit = v_hit[EV_VIS_OFF];

  // Set/clear flags updated on the rising edge
  logic hs_on, hs_on_nxt, vs_on, vs_on_nxt;
  logic h_vis, h_vis_nxt, v_vis, v_vis_nxt;

  vt_sr_flag #(.RST_VAL(1'b0)) u_hs_flag (
    .clk(clk), .rst(rst), .set(hs_set_hit), .clr(hs_clr_hit), .q(hs_on), .q_nxt(hs_on_nxt)
  );
  vt_sr_flag #(.RST_VAL(1'b0)) u_vs_flag (
    .clk(clk), .rst(rst), .set(vs_set_hit), .clr(vs_clr_hit), .q(vs_on), .q_nxt(vs_on_nxt)
  );
  vt_sr_flag #(.RST_VAL(1'b1)) u_hvis_flag (
    .clk(clk), .rst(rst), .set(hv_set_hit), .clr(hv_clr_hit), .q(h_vis), .q_nxt(h_vis_nxt)
  );
  vt_sr_flag #(.RST_VAL(1'b1)) u_vvis_flag (
    .clk(clk), .rst(rst), .set(vv_set_hit), .clr(vv_clr_hit), .q(v_vis), .q_nxt(v_vis_nxt)
  );

  // Visible flag registered alongside the sync flags
  always_ff @(posedge clk) begin
    if (rst) active <= 1'b1;
    else     active <= h_vis_nxt & v_vis_nxt;
  end

  assign hsync_n = ~hs_on;
  assign vsync_n = ~vs_on;

endmodule

// File: rtl/vt_timing_chk.sv
module vt_timing_chk #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int W_COL    = 10,
  parameter int W_ROW    = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             active,
  input logic [W_COL-1:0] col,
  input logic [W_ROW-1:0] row,
  input logic             hs_set_hit,
  input logic             vs_set_hit
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int HS0     = H_ACTIVE + H_FP;
  localparam int HS1     = HS0 + H_SYNC;
  localparam int VS0     = V_ACTIVE + V_FP;

  a_r1_col_wrap: assert property (@(posedge clk) disable iff (rst)
    (col == W_COL'(H_TOTAL-1)) |=> (col == '0));

  a_r1_col_step: assert property (@(posedge clk) disable iff (rst)
    (col != W_COL'(H_TOTAL-1)) |=> (col == $past(col) + 1'b1));

  a_r2_row_hold: assert property (@(posedge clk) disable iff (rst)
    (col != W_COL'(H_TOTAL-1)) |=> $stable(row));

  a_r3_hs_strobe: assert property (@(posedge clk) disable iff (rst)
    hs_set_hit |=> !hsync_n);

  a_r3_vs_strobe: assert property (@(posedge clk) disable iff (rst)
    vs_set_hit |=> !vsync_n);

  a_r4_hs_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> (col == W_COL'(HS0)));

  a_r4_hs_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> (col == W_COL'(HS1)));

  a_r5_vs_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> (col == '0 && row == W_ROW'(VS0)));

  a_r6_active_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (col < W_COL'(H_ACTIVE) && row < W_ROW'(V_ACTIVE)));

endmodule

bind vid_timing_gen vt_timing_chk #(
  .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
  .W_COL(W_COL), .W_ROW(W_ROW)
) u_timing_chk (
  .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n), .active(active),
  .col(col), .row(row), .hs_set_hit(hs_set_hit), .vs_set_hit(vs_set_hit)
);

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;
  // R8: a small raster with narrow counters keeps several frames short
  localparam int HA = 16, HF = 3, HS = 5, HB = 4;
  localparam int VA = 6,  VF = 2, VS = 2, VB = 3;
  localparam int WC = 6,  WR = 5;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_n, vsync_n, active;
  logic [WC-1:0] col;
  logic [WR-1:0] row;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  vid_timing_gen #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .W_COL(WC), .W_ROW(WR)
  ) i_vid_timing_gen (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .active(active), .col(col), .row(row)
  );

  // Reference position
  int hc = 0;
  int vc = 0;
  bit in_reset = 1'b1;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (hc=%0d vc=%0d)", tag, act, exp, hc, vc);
    end
  endtask

  task automatic step(input bit next_rst);
    int s_hs, s_vs, s_act, s_col, s_row;
    @(posedge clk);
    in_reset = rst;
    if (rst) begin
      hc = 0; vc = 0;
    end else begin
      if (hc == HT - 1) begin
        hc = 0;
        vc = (vc == VT - 1) ? 0 : vc + 1;
      end else begin
        hc = hc + 1;
      end
    end
    #1 rst = next_rst;
    #2;
    if (in_reset) begin
      chk("R7 col", int'(col), 0);
      chk("R7 row", int'(row), 0);
      chk("R7 hsync_n", int'(hsync_n), 1);
      chk("R7 vsync_n", int'(vsync_n), 1);
      chk("R7 active", int'(active), 1);
    end else begin
      chk("R1 col", int'(col), hc);
      chk("R2 row", int'(row), vc);
      chk("R4 hsync_n", int'(hsync_n), (hc >= HA + HF && hc < HA + HF + HS) ? 0 : 1);
      chk("R5 vsync_n", int'(vsync_n), (vc >= VA + VF && vc < VA + VF + VS) ? 0 : 1);
      chk("R6 active", int'(active), (hc < HA && vc < VA) ? 1 : 0);
    end
    s_hs = hsync_n; s_vs = vsync_n; s_act = active; s_col = col; s_row = row;
    @(negedge clk);
    #1;
    chk("R3 hsync_n steady over falling edge", int'(hsync_n), s_hs);
    chk("R3 vsync_n steady over falling edge", int'(vsync_n), s_vs);
    chk("R3 active steady over falling edge", int'(active), s_act);
    chk("R3 col steady over falling edge", int'(col), s_col);
    chk("R3 row steady over falling edge", int'(row), s_row);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(i < 2);        // R7 reset state
    for (int i = 0; i < 3 * HT * VT; i++) step(1'b0);  // R1..R6 over three frames
    for (int i = 0; i < 2 * HT + 9; i++) step(1'b0);   // stop mid-line
    step(1'b1);                                          // R7 mid-frame reset
    step(1'b1);
    step(1'b0);
    for (int i = 0; i < HT * VT + 3 * HT; i++) step(1'b0);
    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule